// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Mapper

This block sits between a 16-bit CPU bus and cartridge memory. CPU writes that land in the lower half of the address space (0x0000–0x7FFF) do not reach the ROM. The mapper decodes them as updates to four control fields: a RAM enable, a 5-bit primary ROM bank, a 2-bit secondary bank, and a 1-bit mode flag. CPU reads in the same half are turned into a 21-bit physical ROM byte address, which is enough for 128 banks of 16 KB. The ROM data itself is fetched outside the block.

Reads and writes in the 8 KB external-RAM window (0xA000–0xBFFF) go to a small synchronous byte array inside the block. RAM read data comes back one cycle after the read, together with a valid strobe. Two static configuration codes set the geometry. One gives the ROM size, which decides the bank mask and whether the secondary bits extend the bank number. The other gives the RAM size, which decides the offset wrap and whether RAM banking applies.

The array keeps 2^RAM_ROW_W bytes for each of the four RAM banks (default 1 KB). Offset bits above that width are folded into the row index. A RAM_ROW_W of 13 gives the full 32 KB.

Top module: `cart_bank_mapper`

## Requirements
- R1: A write with address bits [15:13] = 000 sets the RAM enable when data bits [3:0] equal 0xA and clears it for any other value.
- R2: A write with address bits [15:13] = 001 loads the primary bank. A data byte of 0x00 loads 1. Any other byte loads data AND mask. The mask is 0x01, 0x03, 0x07, 0x0F for ROM code 0, 1, 2, 3 (2, 4, 8, 16 banks) and 0x1F for codes 4, 5, 6 (32, 64, 128 banks).
- R3: A write with address bits [15:13] = 010 loads the secondary bank from data bits [1:0]. A write with bits [15:13] = 011 loads the mode flag from data bit 0.
- R4: A read at 0x4000–0x7FFF gives rom_addr = bank × 0x4000 + (addr − 0x4000), with rom_sel high in the same cycle. For ROM codes 0–4 the bank is the masked primary bank.
- R5: In the upper window, ROM code 5 (64 banks) replaces bank bit 5 with secondary bit 0. ROM code 6 (128 banks) replaces bank bits 6:5 with secondary bits 1:0.
- R6: A read at 0x0000–0x3FFF gives rom_addr = addr when mode is 0. When mode is 1 it gives zero_bank × 0x4000 + addr. zero_bank is 0 for codes 0–4, secondary bit 0 at bit 5 for code 5, and secondary bits 1:0 at bits 6:5 for code 6.
- R7: While the RAM enable is clear, or the RAM code is 0 (no RAM), reads in 0xA000–0xBFFF return 0xFF and writes there leave the array unchanged.
- R8: RAM code 1 (2 KB) takes the window offset modulo 0x800. RAM code 2 (8 KB) takes it modulo 0x2000 and ignores the secondary bank.
- R9: RAM code 3 (32 KB) adds secondary × 0x2000 to the offset only when mode is 1; with mode 0 bank 0 is used.
- R10: After reset the primary bank is 1 and the secondary bank, mode and RAM enable are 0; no output strobe is high.
- R11: Reads or writes outside 0x0000–0x7FFF and 0xA000–0xBFFF change no state and raise neither rom_sel nor ram_rvalid.
- R12: A RAM-window read raises ram_rvalid exactly one cycle later with ram_rdata valid in that cycle; ram_rvalid is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe |
| rom_cfg | input | 3 | ROM size code, 0..6 = 2..128 banks |
| ram_cfg | input | 2 | RAM size code: 0 none, 1 2 KB, 2 8 KB, 3 32 KB |
| rom_addr | output | 21 | Physical ROM byte address |
| rom_sel | output | 1 | Current read targets ROM; rom_addr valid |
| ram_rdata | output | 8 | RAM window read data |
| ram_rvalid | output | 1 | ram_rdata valid, one cycle after a RAM read |

## Verification
ROM results are combinational: rom_sel and rom_addr answer the read in the cycle it is presented. The bench drives each access just after a rising edge and compares at the following falling edge. RAM results pass through one register, so the expected byte is compared at the falling edge one full cycle after the read was driven. Register writes take effect at the edge that ends the write cycle, so a read placed in the next cycle already sees the new bank. Expected items wait in two queues, one per result path, and the monitor flags any strobe that arrives with no pending item.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam int CPU_AW    = 16;
  localparam int DW        = 8;
  localparam int LO_W      = 5;
  localparam int HI_W      = 2;
  localparam int BANK_W    = 7;
  localparam int ROM_OFS_W = 14;
  localparam int ROM_AW    = BANK_W + ROM_OFS_W;
  localparam int WIN_W     = 13;

  typedef enum logic [2:0] {
    ROM_B2 = 3'd0, ROM_B4, ROM_B8, ROM_B16, ROM_B32, ROM_B64, ROM_B128
  } rom_cfg_e;

  typedef enum logic [1:0] {
    RAM_NONE = 2'd0, RAM_2K, RAM_8K, RAM_32K
  } ram_cfg_e;

  // bit i of the mask is set when i <= code; codes above 4 saturate at 0x1F
  function automatic logic [LO_W-1:0] bank_mask(input logic [2:0] code);
    logic [LO_W-1:0] m;
    for (int i = 0; i < LO_W; i++) m[i] = (i <= int'(code));
    return m;
  endfunction
endpackage

// File: rtl/cbm_ctl_regs.sv
module cbm_ctl_regs
  import cbm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [1:0]      sel,
  input  logic [DW-1:0]   wdata,
  input  logic [2:0]      rom_cfg,
  output logic            ram_en,
  output logic [LO_W-1:0] bank_lo,
  output logic [HI_W-1:0] bank_hi,
  output logic            mode
);
  logic            en_we, lo_we, hi_we, md_we;
  logic            en_d, md_d;
  logic [LO_W-1:0] lo_d;
  logic [HI_W-1:0] hi_d;

  always_comb begin
    en_we = we && (sel == 2'd0);
    lo_we = we && (sel == 2'd1);
    hi_we = we && (sel == 2'd2);
    md_we = we && (sel == 2'd3);
    en_d  = (wdata[3:0] == 4'hA);
    lo_d  = (wdata == '0) ? LO_W'(1) : (wdata[LO_W-1:0] & bank_mask(rom_cfg));
    hi_d  = wdata[HI_W-1:0];
    md_d  = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_en  <= 1'b0;
      bank_lo <= LO_W'(1);
      bank_hi <= '0;
      mode    <= 1'b0;
    end else begin
      if (en_we) ram_en  <= en_d;
      if (lo_we) bank_lo <= lo_d;
      if (hi_we) bank_hi <= hi_d;
      if (md_we) mode    <= md_d;
    end
  end
endmodule

// File: rtl/cbm_rom_map.sv
module cbm_rom_map
  import cbm_pkg::*;
(
  input  logic [ROM_OFS_W:0] addr,
  input  logic [2:0]         rom_cfg,
  input  logic [LO_W-1:0]    bank_lo,
  input  logic [HI_W-1:0]    bank_hi,
  input  logic               mode,
  output logic [ROM_AW-1:0]  rom_addr
);
  logic [BANK_W-1:0] upper_bank, zero_bank, bank;

  always_comb begin
    upper_bank = {2'b00, bank_lo & bank_mask(rom_cfg)};
    zero_bank  = '0;
    case (rom_cfg_e'(rom_cfg))
      ROM_B64: begin
        upper_bank[5] = bank_hi[0];
        zero_bank[5]  = bank_hi[0];
      end
      ROM_B128: begin
        upper_bank[6:5] = bank_hi;
        zero_bank[6:5]  = bank_hi;
      end
      default: ;
    endcase
    if (addr[ROM_OFS_W])  bank = upper_bank;
    else if (mode)        bank = zero_bank;
    else                  bank = '0;
    rom_addr = {bank, addr[ROM_OFS_W-1:0]};
  end
endmodule

// File: rtl/cbm_ram.sv
module cbm_ram
  import cbm_pkg::*;
#(
  parameter int ROW_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_hit,
  input  logic            wr_hit,
  input  logic [WIN_W-1:0] ofs,
  input  logic [DW-1:0]   wdata,
  input  logic [1:0]      ram_cfg,
  input  logic            ram_en,
  input  logic [HI_W-1:0] bank_hi,
  input  logic            mode,
  output logic [DW-1:0]   rdata,
  output logic            rvalid
);
  localparam int IDX_W = ROW_W + HI_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0]    mem [DEPTH];
  logic [WIN_W-1:0] win_ofs;
  logic [HI_W-1:0]  bank_sel;
  logic [ROW_W-1:0] row;
  logic [IDX_W-1:0] idx;
  logic             access_ok, mem_we;
  logic [DW-1:0]    rdata_d;

  always_comb begin
    win_ofs   = (ram_cfg_e'(ram_cfg) == RAM_2K) ? {2'b00, ofs[10:0]} : ofs;
    bank_sel  = ((ram_cfg_e'(ram_cfg) == RAM_32K) && mode) ? bank_hi : '0;
    access_ok = ram_en && (ram_cfg_e'(ram_cfg) != RAM_NONE);
    mem_we    = wr_hit && access_ok;
  end

  generate
    if (ROW_W >= WIN_W) begin : g_full_row
      assign row = ROW_W'(win_ofs);
    end else begin : g_fold_row
      assign row = win_ofs[ROW_W-1:0] ^ ROW_W'(win_ofs[WIN_W-1:ROW_W]);
    end
  endgenerate

  assign idx     = {bank_sel, row};
  assign rdata_d = access_ok ? mem[idx] : 8'hFF;

  always_ff @(posedge clk) begin
    if (mem_we) mem[idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rd_hit) rdata <= rdata_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= rd_hit;
  end
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cbm_pkg::*;
#(
  parameter int RAM_ROW_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [2:0]        rom_cfg,
  input  logic [1:0]        ram_cfg,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_sel,
  output logic [DW-1:0]     ram_rdata,
  output logic              ram_rvalid
);
  logic [1:0]      rst_pipe;
  logic            rst_sync_n;
  logic            in_ctl, in_ram, ctl_we, ram_rd_hit, ram_wr_hit;
  logic            ram_en, mode;
  logic [LO_W-1:0] bank_lo;
  logic [HI_W-1:0] bank_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  always_comb begin
    in_ctl     = !bus_addr[15];
    in_ram     = (bus_addr[15:13] == 3'b101);
    ctl_we     = bus_wr && in_ctl;
    ram_rd_hit = bus_rd && in_ram;
    ram_wr_hit = bus_wr && in_ram;
    rom_sel    = bus_rd && in_ctl;
  end

  cbm_ctl_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we      (ctl_we),
    .sel     (bus_addr[14:13]),
    .wdata   (bus_wdata),
    .rom_cfg (rom_cfg),
    .ram_en  (ram_en),
    .bank_lo (bank_lo),
    .bank_hi (bank_hi),
    .mode    (mode)
  );

  cbm_rom_map u_rom (
    .addr     (bus_addr[ROM_OFS_W:0]),
    .rom_cfg  (rom_cfg),
    .bank_lo  (bank_lo),
    .bank_hi  (bank_hi),
    .mode     (mode),
    .rom_addr (rom_addr)
  );

  cbm_ram #(.ROW_W(RAM_ROW_W)) u_ram (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_hit  (ram_rd_hit),
    .wr_hit  (ram_wr_hit),
    .ofs     (bus_addr[WIN_W-1:0]),
    .wdata   (bus_wdata),
    .ram_cfg (ram_cfg),
    .ram_en  (ram_en),
    .bank_hi (bank_hi),
    .mode    (mode),
    .rdata   (ram_rdata),
    .rvalid  (ram_rvalid)
  );
endmodule

// File: rtl/cbm_checker.sv
module cbm_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] bus_addr,
  input logic [7:0]  bus_wdata,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic [2:0]  rom_cfg,
  input logic [20:0] rom_addr,
  input logic        rom_sel,
  input logic [7:0]  ram_rdata,
  input logic        ram_rvalid,
  input logic        ram_en,
  input logic [4:0]  bank_lo,
  input logic        mode
);
  logic ram_hit;
  assign ram_hit = bus_rd && (bus_addr[15:13] == 3'b101);

  a_r1_enable_code: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[15:13] == 3'b000) |=> (ram_en == ($past(bus_wdata[3:0]) == 4'hA)));

  a_r2_zero_to_one: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[15:13] == 3'b001 && bus_wdata == 8'h00) |=> (bank_lo == 5'd1));

  a_r2_two_bank_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[15:13] == 3'b001 && rom_cfg == 3'd0) |=> (bank_lo <= 5'd1));

  a_r3_mode_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[15:13] == 3'b011) |=> (mode == $past(bus_wdata[0])));

  a_r4_window_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[15:14] == 2'b01) |-> (rom_sel && rom_addr[13:0] == bus_addr[13:0]));

  a_r6_straight_low: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[15:14] == 2'b00 && !mode) |-> (rom_addr == {5'd0, bus_addr}));

  a_r7_disabled_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_hit && !ram_en) |=> (ram_rdata == 8'hFF));

  a_r11_no_rom_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd || bus_addr[15]) |-> !rom_sel);

  a_r12_rvalid_due: assert property (@(posedge clk) disable iff (!rst_n)
    ram_hit |=> ram_rvalid);

  a_r12_rvalid_only: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_hit |=> !ram_rvalid);
endmodule

bind cart_bank_mapper cbm_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .rom_cfg    (rom_cfg),
  .rom_addr   (rom_addr),
  .rom_sel    (rom_sel),
  .ram_rdata  (ram_rdata),
  .ram_rvalid (ram_rvalid),
  .ram_en     (ram_en),
  .bank_lo    (bank_lo),
  .mode       (mode)
);

// File: tb/cart_bank_mapper_test.sv
module cart_bank_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_rd, bus_wr;
  logic [2:0]  rom_cfg;
  logic [1:0]  ram_cfg;
  logic [20:0] rom_addr;
  logic        rom_sel;
  logic [7:0]  ram_rdata;
  logic        ram_rvalid;

  int n_chk = 0;
  int n_bad = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  logic [20:0] rom_exp_q[$];
  string       rom_tag_q[$];
  logic [7:0]  ram_exp_q[$];
  string       ram_tag_q[$];

  always #5 clk = ~clk;

  cart_bank_mapper uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .rom_cfg(rom_cfg), .ram_cfg(ram_cfg),
    .rom_addr(rom_addr), .rom_sel(rom_sel), .ram_rdata(ram_rdata), .ram_rvalid(ram_rvalid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic rd, input logic wr, input logic [15:0] a, input logic [7:0] d);
    @(posedge clk);
    #1;
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 16'h0000, 8'h00);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    drive(1'b0, 1'b1, a, d);
  endtask

  task automatic set_cfg(input logic [2:0] r, input logic [1:0] m);
    @(posedge clk);
    #1;
    bus_rd = 1'b0; bus_wr = 1'b0;
    rom_cfg = r; ram_cfg = m;
  endtask

  task automatic rom_rd(input logic [15:0] a, input logic [20:0] exp, input string tag);
    rom_exp_q.push_back(exp);
    rom_tag_q.push_back(tag);
    drive(1'b1, 1'b0, a, 8'h00);
  endtask

  task automatic ram_rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
    ram_exp_q.push_back(exp);
    ram_tag_q.push_back(tag);
    drive(1'b1, 1'b0, a, 8'h00);
  endtask

  // read outside both windows: no strobe in this cycle nor the next
  task automatic quiet_rd(input logic [15:0] a);
    drive(1'b1, 1'b0, a, 8'h00);
    @(negedge clk);
    check("R11 rom_sel on out-of-range read", 32'(rom_sel), 32'd0);
    idle();
    @(negedge clk);
    check("R11 ram_rvalid after out-of-range read", 32'(ram_rvalid), 32'd0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (ram_rvalid) begin
        if (ram_exp_q.size() == 0) check("R12 unexpected ram_rvalid", 32'd1, 32'd0);
        else check(ram_tag_q.pop_front(), 32'(ram_rdata), 32'(ram_exp_q.pop_front()));
      end
      if (rom_sel) begin
        if (rom_exp_q.size() == 0) check("R11 unexpected rom_sel", 32'd1, 32'd0);
        else check(rom_tag_q.pop_front(), 32'(rom_addr), 32'(rom_exp_q.pop_front()));
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rom_cfg = 3'd4; ram_cfg = 2'd3;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 rom_sel after reset", 32'(rom_sel), 32'd0);
    check("R10 ram_rvalid after reset", 32'(ram_rvalid), 32'd0);
    mon_on = 1'b1;

    // R10 reset state seen through reads
    rom_rd(16'h4000, 21'h004000, "R10 primary bank 1 after reset");
    rom_rd(16'h0123, 21'h000123, "R10 mode 0 after reset");
    ram_rd(16'hA000, 8'hFF, "R10 RAM disabled after reset");

    // R2 primary bank loading and masking, R4 upper window
    wr(16'h2000, 8'h00);
    rom_rd(16'h4ABC, 21'h004ABC, "R2 zero write becomes bank 1");
    wr(16'h2100, 8'h13);
    rom_rd(16'h7FFF, 21'h04FFFF, "R4 bank 0x13 top byte");
    set_cfg(3'd1, 2'd3);
    wr(16'h3000, 8'h07);
    rom_rd(16'h4001, 21'h00C001, "R2 4-bank mask keeps 3");
    wr(16'h2000, 8'h04);
    rom_rd(16'h4002, 21'h000002, "R2 masked value 0 stays 0");

    // R5 large ROM bank extension
    set_cfg(3'd5, 2'd3);
    wr(16'h2000, 8'h1F);
    wr(16'h4000, 8'h03);
    rom_rd(16'h5000, 21'h0FD000, "R5 64 banks secondary bit 0");
    set_cfg(3'd6, 2'd3);
    rom_rd(16'h5000, 21'h1FD000, "R5 128 banks secondary bits");
    set_cfg(3'd4, 2'd3);
    rom_rd(16'h5000, 21'h07D000, "R4 32 banks ignores secondary");

    // R6 low window in mode 1, R3 mode from bit 0
    wr(16'h6000, 8'h01);
    set_cfg(3'd6, 2'd3);
    rom_rd(16'h0010, 21'h180010, "R6 mode 1 128-bank zero window");
    set_cfg(3'd5, 2'd3);
    rom_rd(16'h0010, 21'h080010, "R6 mode 1 64-bank zero window");
    set_cfg(3'd4, 2'd3);
    rom_rd(16'h0010, 21'h000010, "R6 mode 1 32-bank stays bank 0");
    wr(16'h7FFF, 8'hFE);
    set_cfg(3'd6, 2'd3);
    rom_rd(16'h0010, 21'h000010, "R3 mode cleared by bit 0 = 0");

    // R1 enable code, R7 disabled access
    wr(16'h0000, 8'h5A);
    wr(16'hA005, 8'h11);
    ram_rd(16'hA005, 8'h11, "R1 enable with low nibble A");
    wr(16'h1FFF, 8'h0B);
    ram_rd(16'hA005, 8'hFF, "R1 other value disables");
    wr(16'hA005, 8'h22);
    wr(16'h0000, 8'hFA);
    ram_rd(16'hA005, 8'h11, "R7 write while disabled ignored");

    // R9 32 KB banking by mode
    wr(16'h4000, 8'h02);
    wr(16'h6000, 8'h01);
    wr(16'hA005, 8'h33);
    ram_rd(16'hA005, 8'h33, "R9 mode 1 bank 2");
    wr(16'h6000, 8'h00);
    ram_rd(16'hA005, 8'h11, "R9 mode 0 uses bank 0");
    wr(16'h6000, 8'h01);
    ram_rd(16'hA005, 8'h33, "R9 mode 1 bank 2 again");

    // R8 small RAM sizes
    set_cfg(3'd4, 2'd2);
    ram_rd(16'hA005, 8'h11, "R8 8 KB ignores secondary bank");
    set_cfg(3'd4, 2'd1);
    wr(16'hA810, 8'h55);
    ram_rd(16'hA010, 8'h55, "R8 2 KB wraps 0x810 to 0x010");
    ram_rd(16'hB810, 8'h55, "R8 2 KB wraps 0x1810 to 0x010");
    set_cfg(3'd4, 2'd2);
    ram_rd(16'hA010, 8'h55, "R8 8 KB offset 0x010");

    // R7 no RAM fitted
    set_cfg(3'd4, 2'd0);
    ram_rd(16'hA005, 8'hFF, "R7 no RAM reads 0xFF");

    // R11 out-of-range accesses
    set_cfg(3'd4, 2'd3);
    wr(16'h0000, 8'h00);
    wr(16'hE000, 8'h0A);
    wr(16'h8000, 8'h0A);
    ram_rd(16'hA005, 8'hFF, "R11 out-of-range write left RAM disabled");
    idle();
    quiet_rd(16'h8000);
    quiet_rd(16'h9FFF);
    quiet_rd(16'hC000);
    quiet_rd(16'hFFFF);

    // R12 back-to-back timing
    wr(16'h0000, 8'h0A);
    ram_rd(16'hA005, 8'h33, "R12 first of back-to-back");
    ram_rd(16'hA005, 8'h33, "R12 second of back-to-back");
    rom_rd(16'h0100, 21'h000100, "R12 ROM read beside RAM result");
    idle();
    idle();
    idle();
    @(negedge clk);
    check("R12 all RAM results delivered", 32'(ram_exp_q.size()), 32'd0);
    check("R4 all ROM results delivered", 32'(rom_exp_q.size()), 32'd0);
    done = 1'b1;
    finish_run();
  end
endmodule